// File: doc/BRIEF.md
# Storage Attribute Resolution Unit

This block decides, for every memory access, which storage attributes apply and whether the access may proceed as issued. It receives the access address, the access kind (instruction fetch, load or store), a flag saying whether the access is speculative, a flag saying whether address translation is on, and the four attribute bits of the translation entry that matched. With translation on, the attributes are taken from that entry. With translation off (real mode), the guarded, user-defined and little-endian attributes come from three software-writable region masks, each dividing the address space into equal regions selected by the top address bits. The coherent attribute is carried through but changes nothing.

From the resolved attributes the block raises three combinational requests in the same cycle as the access: an instruction storage fault for a fetch from a guarded page under translation, a drain stall that holds a real-mode guarded fetch until the pipeline is empty, and a speculation block that stops any speculative touch of a guarded location. It also drives the byte-lane swap and decompression-enable controls that follow from the little-endian and user-defined attributes.

Top module: `storage_attr_unit`

## Requirements
- R1: After reset all three region masks hold zero, so a real-mode access reports guarded, user-defined, little-endian and coherent all 0 at every address.
- R2: With `xlate_en`=1, `res_coherent`, `res_guarded`, `res_user` and `res_little` equal `ent_coherent`, `ent_guarded`, `ent_user` and `ent_little` in the same cycle.
- R3: With `xlate_en`=0, region index k = `acc_addr[31:27]`; `res_guarded`, `res_user` and `res_little` equal bit k of the guard, user and endian masks respectively, and `res_coherent` is 0.
- R4: A clock edge with `cfg_we`=1 loads `cfg_wdata` into the mask chosen by `cfg_sel` (0 guard, 1 user, 2 endian), visible from the following cycle; `cfg_sel`=3 changes no mask.
- R5: `fetch_fault` is 1 exactly when `acc_valid`=1, `acc_kind`=0 (fetch), `xlate_en`=1 and the resolved guarded bit is 1.
- R6: `drain_stall` is 1 exactly when `acc_valid`=1, `acc_kind`=0, `xlate_en`=0, the resolved guarded bit is 1 and `pipe_empty`=0.
- R7: `fetch_fault` and `drain_stall` are never 1 together, and neither is 1 for a load (`acc_kind`=1), a store (`acc_kind`=2) or kind 3.
- R8: `spec_block` is 1 exactly when `acc_valid`=1, `acc_spec`=1, the resolved guarded bit is 1 and `fetch_fault` is 0.
- R9: `lane_swap` equals `acc_valid` AND resolved little-endian, `decomp_en` equals `acc_valid` AND resolved user-defined, and the coherent bit affects none of the request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 other data access |
| acc_spec | input | 1 | Access is speculative (prefetch or out-of-order load) |
| xlate_en | input | 1 | Translation enabled for this access |
| pipe_empty | input | 1 | Execution pipeline has drained |
| ent_coherent | input | 1 | Coherent bit of matching entry |
| ent_guarded | input | 1 | Guarded bit of matching entry |
| ent_user | input | 1 | User-defined bit of matching entry |
| ent_little | input | 1 | Little-endian bit of matching entry |
| cfg_we | input | 1 | Region mask write strobe |
| cfg_sel | input | 2 | Mask select: 0 guard, 1 user, 2 endian, 3 none |
| cfg_wdata | input | 32 | Region mask write data |
| res_coherent | output | 1 | Resolved coherent attribute |
| res_guarded | output | 1 | Resolved guarded attribute |
| res_user | output | 1 | Resolved user-defined attribute |
| res_little | output | 1 | Resolved little-endian attribute |
| lane_swap | output | 1 | Byte-lane swap control |
| decomp_en | output | 1 | Decompression enable control |
| fetch_fault | output | 1 | Instruction storage fault request |
| drain_stall | output | 1 | Hold fetch until pipeline empty |
| spec_block | output | 1 | Block speculative access to guarded location |

## Verification
On every cycle the assertions check that fault and stall are exclusive and confined to fetches in the proper mode, that translated attributes follow the entry, that a speculation block only appears on guarded speculative accesses, and that a mask write is reflected at the written region on the next real-mode access. Only the bench's scenarios can show that reset clears every region, that the unused select value leaves all masks intact, and that each region bit maps to the right slice of the address space, since those need writes followed by sweeps of addresses across modes and access kinds.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int unsigned N_MASKS = 3;

   typedef enum logic [1:0] {
      KIND_FETCH = 2'd0,
      KIND_LOAD  = 2'd1,
      KIND_STORE = 2'd2,
      KIND_OTHER = 2'd3
   } acc_kind_e;

   localparam logic [1:0] SEL_GUARD  = 2'd0;
   localparam logic [1:0] SEL_USER   = 2'd1;
   localparam logic [1:0] SEL_ENDIAN = 2'd2;

   typedef struct packed {
      logic coherent;
      logic guarded;
      logic user;
      logic little;
   } attr_t;
endpackage

// File: rtl/sar_region_masks.sv
module sar_region_masks #(
   parameter int unsigned N_REGIONS = 32,
   parameter int unsigned N_MASKS   = 3,
   localparam int unsigned SEL_W    = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [SEL_W-1:0]                    wr_sel,
   input  logic [N_REGIONS-1:0]                wr_data,
   output logic [N_MASKS-1:0][N_REGIONS-1:0]   masks
);
   initial begin
      if (N_MASKS > (1 << SEL_W))
         $error("sar_region_masks: too many masks for select width");
   end

   for (genvar g = 0; g < N_MASKS; g++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            masks[g] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(g)))
            masks[g] <= wr_data;
      end
   end
endmodule

// File: rtl/sar_region_lookup.sv
module sar_region_lookup #(
   parameter int unsigned REGION_BITS = 5,
   parameter int unsigned N_MASKS     = 3,
   localparam int unsigned N_REGIONS  = 1 << REGION_BITS
) (
   input  logic [REGION_BITS-1:0]              region,
   input  logic [N_MASKS-1:0][N_REGIONS-1:0]   masks,
   output logic [N_MASKS-1:0]                  bits
);
   for (genvar g = 0; g < N_MASKS; g++) begin : g_pick
      assign bits[g] = masks[g][region];
   end
endmodule

// File: rtl/sar_attr_select.sv
module sar_attr_select
   import sar_pkg::*;
(
   input  logic   xlate_en,
   input  attr_t  ent_attr,
   input  logic   real_guarded,
   input  logic   real_user,
   input  logic   real_little,
   output attr_t  res_attr
);
   always_comb begin
      if (xlate_en) begin
         res_attr = ent_attr;
      end else begin
         res_attr.coherent = 1'b0;
         res_attr.guarded  = real_guarded;
         res_attr.user     = real_user;
         res_attr.little   = real_little;
      end
   end
endmodule

// File: rtl/sar_guard_ctrl.sv
module sar_guard_ctrl
   import sar_pkg::*;
(
   input  logic        acc_valid,
   input  logic [1:0]  acc_kind,
   input  logic        acc_spec,
   input  logic        xlate_en,
   input  logic        pipe_empty,
   input  logic        guarded,
   output logic        fetch_fault,
   output logic        drain_stall,
   output logic        spec_block
);
   logic is_fetch;
   logic guarded_fetch;

   always_comb begin
      is_fetch      = (acc_kind == KIND_FETCH);
      guarded_fetch = acc_valid && is_fetch && guarded;
      fetch_fault   = guarded_fetch && xlate_en;
      drain_stall   = guarded_fetch && !xlate_en && !pipe_empty;
      spec_block    = acc_valid && acc_spec && guarded && !fetch_fault;
   end
endmodule

// File: rtl/storage_attr_unit.sv
module storage_attr_unit
   import sar_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned REGION_BITS = 5,
   localparam int unsigned N_REGIONS  = 1 << REGION_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [1:0]            acc_kind,
   input  logic                  acc_spec,
   input  logic                  xlate_en,
   input  logic                  pipe_empty,
   input  logic                  ent_coherent,
   input  logic                  ent_guarded,
   input  logic                  ent_user,
   input  logic                  ent_little,
   input  logic                  cfg_we,
   input  logic [1:0]            cfg_sel,
   input  logic [N_REGIONS-1:0]  cfg_wdata,
   output logic                  res_coherent,
   output logic                  res_guarded,
   output logic                  res_user,
   output logic                  res_little,
   output logic                  lane_swap,
   output logic                  decomp_en,
   output logic                  fetch_fault,
   output logic                  drain_stall,
   output logic                  spec_block
);
   initial begin
      if (REGION_BITS == 0 || REGION_BITS > ADDR_W)
         $error("storage_attr_unit: REGION_BITS must be 1..ADDR_W");
   end

   logic [N_MASKS-1:0][N_REGIONS-1:0] masks;
   logic [N_MASKS-1:0]                real_bits;
   logic [REGION_BITS-1:0]            region;
   attr_t                             ent_attr;
   attr_t                             res_attr;

   assign region = acc_addr[ADDR_W-1 -: REGION_BITS];

   if (REGION_BITS < ADDR_W) begin : g_low_unused
      logic unused_low_addr;
      assign unused_low_addr = ^acc_addr[ADDR_W-REGION_BITS-1:0];
   end

   sar_region_masks #(
      .N_REGIONS (N_REGIONS),
      .N_MASKS   (N_MASKS)
   ) u_masks (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .masks   (masks)
   );

   sar_region_lookup #(
      .REGION_BITS (REGION_BITS),
      .N_MASKS     (N_MASKS)
   ) u_lookup (
      .region (region),
      .masks  (masks),
      .bits   (real_bits)
   );

   assign ent_attr = '{coherent: ent_coherent, guarded: ent_guarded,
                       user: ent_user, little: ent_little};

   sar_attr_select u_select (
      .xlate_en     (xlate_en),
      .ent_attr     (ent_attr),
      .real_guarded (real_bits[SEL_GUARD]),
      .real_user    (real_bits[SEL_USER]),
      .real_little  (real_bits[SEL_ENDIAN]),
      .res_attr     (res_attr)
   );

   sar_guard_ctrl u_guard (
      .acc_valid   (acc_valid),
      .acc_kind    (acc_kind),
      .acc_spec    (acc_spec),
      .xlate_en    (xlate_en),
      .pipe_empty  (pipe_empty),
      .guarded     (res_attr.guarded),
      .fetch_fault (fetch_fault),
      .drain_stall (drain_stall),
      .spec_block  (spec_block)
   );

   assign res_coherent = res_attr.coherent;
   assign res_guarded  = res_attr.guarded;
   assign res_user     = res_attr.user;
   assign res_little   = res_attr.little;
   assign lane_swap    = acc_valid && res_attr.little;
   assign decomp_en    = acc_valid && res_attr.user;
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned REGION_BITS = 5,
   localparam int unsigned N_REGIONS  = 1 << REGION_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [1:0]            acc_kind,
   input  logic                  acc_spec,
   input  logic                  xlate_en,
   input  logic                  pipe_empty,
   input  logic                  ent_coherent,
   input  logic                  ent_guarded,
   input  logic                  ent_user,
   input  logic                  ent_little,
   input  logic                  cfg_we,
   input  logic [1:0]            cfg_sel,
   input  logic [N_REGIONS-1:0]  cfg_wdata,
   input  logic                  res_coherent,
   input  logic                  res_guarded,
   input  logic                  res_user,
   input  logic                  res_little,
   input  logic                  fetch_fault,
   input  logic                  drain_stall,
   input  logic                  spec_block
);
   logic [REGION_BITS-1:0] region;
   assign region = acc_addr[ADDR_W-1 -: REGION_BITS];

   // R7: fault and stall never together
   a_r7_fault_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_fault && drain_stall));

   // R7: data accesses never fault or stall
   a_r7_data_no_request: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind != 2'd0) |-> !(fetch_fault || drain_stall));

   // R5: fault only under translation
   a_r5_fault_translated: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_fault |-> (xlate_en && acc_valid && ent_guarded));

   // R6: stall only in real mode with pipeline busy
   a_r6_stall_real: assert property (@(posedge clk) disable iff (!rst_n)
      drain_stall |-> (!xlate_en && !pipe_empty && acc_valid));

   // R2: translated attributes follow the entry
   a_r2_entry_follow: assert property (@(posedge clk) disable iff (!rst_n)
      xlate_en |-> (res_coherent == ent_coherent && res_guarded == ent_guarded
                    && res_user == ent_user && res_little == ent_little));

   // R3: real mode never reports coherent
   a_r3_real_no_coherent: assert property (@(posedge clk) disable iff (!rst_n)
      !xlate_en |-> !res_coherent);

   // R8: speculation block needs guarded speculative access
   a_r8_spec_needs_guard: assert property (@(posedge clk) disable iff (!rst_n)
      spec_block |-> (acc_spec && res_guarded && !fetch_fault));

   // R4: guard mask write shows at the written region
   a_r4_guard_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd0) |=>
         (xlate_en || (res_guarded == $past(cfg_wdata[region]))));
endmodule

bind storage_attr_unit sar_checker #(
   .ADDR_W      (ADDR_W),
   .REGION_BITS (REGION_BITS)
) u_sar_checker (.*);

// File: tb/tb_storage_attr_unit.sv
module tb_storage_attr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_kind = '0;
   logic        acc_spec = 1'b0;
   logic        xlate_en = 1'b0;
   logic        pipe_empty = 1'b1;
   logic        ent_coherent = 1'b0, ent_guarded = 1'b0, ent_user = 1'b0, ent_little = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        res_coherent, res_guarded, res_user, res_little;
   logic        lane_swap, decomp_en, fetch_fault, drain_stall, spec_block;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_guard = '0, m_user = '0, m_endian = '0;

   always #2 clk = ~clk;

   storage_attr_unit dut (.*);

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      logic [4:0] k;
      logic eg, eu, el, ec, ff, ds, sb;
      k  = acc_addr[31:27];
      ec = xlate_en ? ent_coherent : 1'b0;
      eg = xlate_en ? ent_guarded  : m_guard[k];
      eu = xlate_en ? ent_user     : m_user[k];
      el = xlate_en ? ent_little   : m_endian[k];
      ff = acc_valid && acc_kind == 2'd0 && xlate_en && eg;
      ds = acc_valid && acc_kind == 2'd0 && !xlate_en && eg && !pipe_empty;
      sb = acc_valid && acc_spec && eg && !ff;
      chk(xlate_en ? "R2" : "R3", "res_coherent", res_coherent, ec);
      chk(xlate_en ? "R2" : "R3", "res_guarded",  res_guarded,  eg);
      chk(xlate_en ? "R2" : "R3", "res_user",     res_user,     eu);
      chk(xlate_en ? "R2" : "R3", "res_little",   res_little,   el);
      chk("R5", "fetch_fault", fetch_fault, ff);
      chk("R6", "drain_stall", drain_stall, ds);
      chk("R7", "fault_and_stall", fetch_fault && drain_stall, 1'b0);
      chk("R8", "spec_block", spec_block, sb);
      chk("R9", "lane_swap", lane_swap, acc_valid && el);
      chk("R9", "decomp_en", decomp_en, acc_valid && eu);
   endtask

   task automatic access(input logic v, input logic [31:0] a, input logic [1:0] kd,
                         input logic sp, input logic xl, input logic pe, input logic [3:0] ent);
      @(negedge clk);
      cfg_we = 1'b0;
      acc_valid = v; acc_addr = a; acc_kind = kd; acc_spec = sp;
      xlate_en = xl; pipe_empty = pe;
      {ent_coherent, ent_guarded, ent_user, ent_little} = ent;
      #1 check_all();
   endtask

   task automatic write_mask(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk);
      case (sel)
         2'd0: m_guard  = d;
         2'd1: m_user   = d;
         2'd2: m_endian = d;
         default: ;
      endcase
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R1: reset state, real mode, several regions
      for (int r = 0; r < 32; r += 7) begin
         access(1'b1, {r[4:0], 27'h123}, 2'd1, 1'b1, 1'b0, 1'b0, 4'b0000);
         chk("R1", "reset_guarded", res_guarded, 1'b0);
         chk("R1", "reset_user", res_user, 1'b0);
         chk("R1", "reset_little", res_little, 1'b0);
      end

      // R4/R3: region bit mapping at the edges
      write_mask(2'd0, 32'h8000_0001);
      access(1'b1, 32'hF800_0000, 2'd1, 1'b0, 1'b0, 1'b1, 4'b0);
      chk("R3", "region31_guarded", res_guarded, 1'b1);
      access(1'b1, 32'h07FF_FFFF, 2'd1, 1'b0, 1'b0, 1'b1, 4'b0);
      chk("R3", "region0_guarded", res_guarded, 1'b1);
      access(1'b1, 32'h0800_0000, 2'd1, 1'b0, 1'b0, 1'b1, 4'b0);
      chk("R3", "region1_guarded", res_guarded, 1'b0);

      // R4: select 3 changes no mask
      write_mask(2'd3, 32'hFFFF_FFFF);
      access(1'b1, 32'h4000_0000, 2'd1, 1'b0, 1'b0, 1'b1, 4'b0);
      chk("R4", "sel3_guarded", res_guarded, 1'b0);
      chk("R4", "sel3_user", res_user, 1'b0);
      chk("R4", "sel3_little", res_little, 1'b0);

      // R6: real-mode guarded fetch stalls until pipeline empty
      access(1'b1, 32'hF800_0004, 2'd0, 1'b0, 1'b0, 1'b0, 4'b0);
      chk("R6", "stall_busy", drain_stall, 1'b1);
      access(1'b1, 32'hF800_0004, 2'd0, 1'b0, 1'b0, 1'b1, 4'b0);
      chk("R6", "stall_drained", drain_stall, 1'b0);

      // R5: translated guarded fetch faults, even with speculation flag
      access(1'b1, 32'h1000_0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'b0100);
      chk("R5", "fault_fetch", fetch_fault, 1'b1);
      chk("R8", "no_block_on_fault", spec_block, 1'b0);
      // R7: guarded store does not fault
      access(1'b1, 32'h1000_0000, 2'd2, 1'b1, 1'b1, 1'b0, 4'b0100);
      chk("R7", "store_no_fault", fetch_fault, 1'b0);
      chk("R8", "store_spec_block", spec_block, 1'b1);
      // R9: coherent alone drives no request
      access(1'b1, 32'h2000_0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'b1000);
      chk("R9", "coherent_no_request", fetch_fault | drain_stall | spec_block, 1'b0);

      // Random phase
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 9) == 0)
            write_mask(2'($urandom_range(0, 3)), $urandom);
         access(1'($urandom_range(0, 7) != 0), $urandom, 2'($urandom_range(0, 3)),
                1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule